// File: doc/BRIEF.md
# Doubleword Boundary Transfer Splitter

This block sits between a requester that issues byte-addressed loads and stores of one, two or four bytes and a bus sequencer that only understands doubleword-addressed cycles on a 32-bit data bus. Each accepted request is examined for where its bytes fall. When every byte lies inside one doubleword, the block issues a single bus cycle. When the bytes straddle a doubleword boundary, it issues two cycles. The bus side receives the doubleword address (byte address bits above bit 1), four active-low byte enables, and write data already moved onto the correct byte lanes.

For a split transfer the upper doubleword (byte address plus four) is visited first, carrying the bytes that spilled past the boundary on the low lanes. The lower doubleword follows, carrying the remaining bytes on the high lanes. On reads the block keeps the words returned by both cycles and hands the requester one right-justified result. There is exactly one completion per request, and it arrives only after the last bus cycle. A size code outside the legal set is answered at once with an error and never reaches the bus.

All three sides use valid/ready handshakes, and a transfer happens on a rising clock edge where both valid and ready are high. Once the block raises valid on the bus side or on the completion side, it holds that valid and all the qualified fields steady until the partner raises ready. The partner may hold ready low for any number of cycles. The request side takes a new request only while the block is idle, and the block cannot be stalled into dropping work.

Top module: `msplit_xfer`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: bus_addr carries byte address bits 31:2 of the doubleword being accessed. bus_be_n bit n is low exactly when data lane 8n+7:8n holds a transfer byte. For an aligned request this is one cycle at address bits 31:2, with enables low for lanes offset through offset+bytes-1, where offset is address bits 1:0.
- R3: A request whose offset plus byte count exceeds 4 is issued as two cycles. The first goes to doubleword address+1 with the overflow bytes on the lowest lanes. The second goes to the request's own doubleword with the leading bytes on the highest lanes.
- R4: In every bus cycle of a write, bus_wdata is req_wdata rotated left by 8 times the offset, so request byte i sits on lane (offset+i) mod 4. bus_write equals the request's write flag.
- R5: For a read, rsp_rdata byte i is the byte returned on lane (offset+i) mod 4 by the cycle that accessed that byte's doubleword, for i below the byte count. Higher bytes are zero. For writes and errors rsp_rdata is zero.
- R6: Each request produces exactly one completion, raised only after its last bus cycle. req_ready stays low from acceptance until that completion is taken.
- R7: Size codes 0, 1 and 3 mean 1, 2 and 4 bytes. Code 2 gives a completion with rsp_err=1 on the next cycle and no bus cycle. Legal codes give rsp_err=0.
- R8: While bus_valid is high and bus_ready is low, bus_valid, bus_addr, bus_be_n, bus_write and bus_wdata keep their values in the next cycle. The same holds for rsp_valid, rsp_err and rsp_rdata while rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 2 | Size code: 0 byte, 1 two bytes, 3 four bytes |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store data, right-justified |
| bus_valid | output | 1 | Bus cycle request |
| bus_ready | input | 1 | Bus cycle complete; bus_rdata valid on reads |
| bus_addr | output | ADDR_W-2 | Doubleword address |
| bus_be_n | output | 4 | Active-low byte enables, bit n for lane n |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Load data from the bus |
| rsp_valid | output | 1 | Completion present |
| rsp_ready | input | 1 | Requester takes the completion |
| rsp_err | output | 1 | Illegal size code |
| rsp_rdata | output | 32 | Right-justified load result |

## Verification
Two things can fall on the same edge. The handshake that ends the first bus cycle of a split transfer is also the edge where the second cycle's address and enables must take over. The handshake that ends the last cycle is also where the returned word must be captured into the merge before the completion rises. The bench provokes both by raising bus_ready at random, including in the very first cycle that bus_valid appears, and by delaying rsp_ready at random. It judges them by checking the address, enables and data at every cycle that bus_valid is high. It also rebuilds the expected read result byte by byte from a model memory that is keyed on the doubleword address the block drove.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
  localparam int LANES = 4;
  localparam int DW    = LANES * 8;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } xfer_st_t;
endpackage

// File: rtl/msplit_plan.sv
module msplit_plan
  import msplit_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic             legal,
  output logic             split,
  output logic [LANES-1:0] lo_mask,
  output logic [LANES-1:0] hi_mask,
  output logic [LANES-1:0] keep
);
  logic [2*LANES-1:0] span;
  logic [OFF_W:0]     nbytes;

  always_comb begin
    legal  = (size != 2'd2);
    nbytes = '0;
    unique case (size)
      2'd0:    nbytes = (OFF_W+1)'(1);
      2'd1:    nbytes = (OFF_W+1)'(2);
      2'd3:    nbytes = (OFF_W+1)'(LANES);
      default: nbytes = '0;
    endcase
    for (int i = 0; i < LANES; i++) begin
      keep[i] = ((OFF_W+1)'(i) < nbytes);
    end
    span    = {{LANES{1'b0}}, keep} << off;
    lo_mask = span[LANES-1:0];
    hi_mask = span[2*LANES-1:LANES];
    split   = |hi_mask;
  end
endmodule

// File: rtl/msplit_rotate.sv
module msplit_rotate
  import msplit_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout
);
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      logic [OFF_W-1:0] src;
      src = OFF_W'(j) - off;
      dout[8*j +: 8] = din[8*src +: 8];
    end
  end
endmodule

// File: rtl/msplit_merge.sv
module msplit_merge
  import msplit_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [LANES-1:0] keep,
  input  logic [DW-1:0]    word_lo,
  input  logic [DW-1:0]    word_hi,
  output logic [DW-1:0]    dout
);
  logic [2*DW-1:0] both;

  always_comb begin
    both = {word_hi, word_lo};
    for (int j = 0; j < LANES; j++) begin
      logic [OFF_W:0] src;
      src = {1'b0, off} + (OFF_W+1)'(j);
      dout[8*j +: 8] = keep[j] ? both[8*src +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/msplit_xfer.sv
module msplit_xfer
  import msplit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-3:0] bus_addr,
  output logic [LANES-1:0]  bus_be_n,
  output logic              bus_write,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int DWA_W = ADDR_W - OFF_W;

  xfer_st_t         state;
  logic [DWA_W-1:0] dw_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q, err_q, split_q;
  logic [DW-1:0]    wd_q, word_lo, word_hi;
  logic [LANES-1:0] lo_q, hi_q, keep_q;

  logic             p_legal, p_split;
  logic [LANES-1:0] p_lo, p_hi, p_keep;
  logic [DW-1:0]    rot_w, merged;

  msplit_plan u_plan (
    .off     (req_addr[OFF_W-1:0]),
    .size    (req_size),
    .legal   (p_legal),
    .split   (p_split),
    .lo_mask (p_lo),
    .hi_mask (p_hi),
    .keep    (p_keep)
  );

  msplit_rotate u_rot (
    .off  (req_addr[OFF_W-1:0]),
    .din  (req_wdata),
    .dout (rot_w)
  );

  msplit_merge u_merge (
    .off     (off_q),
    .keep    (keep_q),
    .word_lo (word_lo),
    .word_hi (word_hi),
    .dout    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dw_q    <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      split_q <= 1'b0;
      wd_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      keep_q  <= '0;
      word_lo <= '0;
      word_hi <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          dw_q    <= req_addr[ADDR_W-1:OFF_W];
          off_q   <= req_addr[OFF_W-1:0];
          wr_q    <= req_write;
          err_q   <= !p_legal;
          split_q <= p_split;
          wd_q    <= rot_w;
          lo_q    <= p_lo;
          hi_q    <= p_hi;
          keep_q  <= p_keep;
          state   <= p_legal ? ST_FIRST : ST_DONE;
        end
        ST_FIRST: if (bus_ready) begin
          if (split_q) begin
            word_hi <= bus_rdata;
            state   <= ST_SECOND;
          end else begin
            word_lo <= bus_rdata;
            state   <= ST_DONE;
          end
        end
        ST_SECOND: if (bus_ready) begin
          word_lo <= bus_rdata;
          state   <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    bus_valid = (state == ST_FIRST) || (state == ST_SECOND);
    bus_write = wr_q;
    bus_wdata = wd_q;
    if (state == ST_FIRST && split_q) begin
      bus_addr = dw_q + DWA_W'(1);
      bus_be_n = ~hi_q;
    end else begin
      bus_addr = dw_q;
      bus_be_n = ~lo_q;
    end
    rsp_valid = (state == ST_DONE);
    rsp_err   = err_q;
    rsp_rdata = (err_q || wr_q) ? '0 : merged;
  end

  // R8: bus request held while stalled
  a_r8_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be_n)
      && $stable(bus_wdata) && $stable(bus_write));

  // R8: completion held while stalled
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R7: illegal size goes straight to an error completion
  a_r7_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_size == 2'd2 |=> rsp_valid && rsp_err && !bus_valid);

  // R3: second cycle of a split addresses the doubleword just below
  a_r3_second_below: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_be_n[0] == 1'b0 && bus_be_n[LANES-1] == 1'b1 && !req_ready
      && $countones(~bus_be_n) < LANES && split_q && state == ST_FIRST
    |=> bus_valid && bus_addr == $past(bus_addr) - DWA_W'(1));

  // R2: every bus cycle enables at least one lane
  a_r2_some_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(~bus_be_n) >= 1);

  // R6: never idle-ready while a bus cycle or completion is pending
  a_r6_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (bus_valid || rsp_valid)));
endmodule

// File: tb/msplit_xfer_tb.sv
module msplit_xfer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  msplit_xfer u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E3779B1) ^ 32'hA5C3_1E77;
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic do_xfer(input logic [31:0] a, input logic [1:0] s, input bit wr, input logic [31:0] wd);
    logic [29:0] exp_addr [2];
    logic [3:0]  exp_en   [2];
    logic [31:0] exp_wd, exp_rd;
    int n, ncyc, k, guard;
    bit done;
    n = nbytes(s);
    exp_en[0] = 4'h0; exp_en[1] = 4'h0;
    exp_wd = '0; exp_rd = '0;
    ncyc = (s == 2'd2) ? 0 : ((int'(a[1:0]) + n > 4) ? 2 : 1);
    exp_addr[0] = (ncyc == 2) ? a[31:2] + 30'd1 : a[31:2];
    exp_addr[1] = a[31:2];
    for (int i = 0; i < 4; i++) exp_wd[8*((i + int'(a[1:0])) % 4) +: 8] = wd[8*i +: 8];
    if (ncyc > 0) begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] b;
        logic [31:0] w;
        b = a + 32'(i);
        w = mem_word(b[31:2]);
        if (!wr) exp_rd[8*i +: 8] = w[8*b[1:0] +: 8];
        if (b[31:2] == exp_addr[0]) exp_en[0][b[1:0]] = 1'b1;
        else exp_en[1][b[1:0]] = 1'b1;
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; guard = 0; done = 1'b0;
    while (!done) begin
      bus_ready = 1'b0; rsp_ready = 1'b0;
      if (bus_valid) begin
        if (k >= ncyc) chk(1'b0, "R7 unexpected bus cycle", 64'(k), 64'(ncyc));
        else begin
          chk(bus_addr == exp_addr[k], (k == 0 && ncyc == 2) ? "R3 first addr" : "R2 addr", 64'(bus_addr), 64'(exp_addr[k]));
          chk(bus_be_n == ~exp_en[k], (ncyc == 2) ? "R3 enables" : "R2 enables", 64'(bus_be_n), 64'(~exp_en[k]));
          chk(bus_write == wr, "R4 direction", 64'(bus_write), 64'(wr));
          if (wr) chk(bus_wdata == exp_wd, "R4 lane data", 64'(bus_wdata), 64'(exp_wd));
        end
        chk(req_ready == 1'b0, "R6 busy", 64'(req_ready), 64'd0);
        if ($urandom % 3 == 0) begin
          bus_ready = 1'b1;
          bus_rdata = mem_word(bus_addr);
          k++;
        end else bus_rdata = $urandom;
      end
      if (rsp_valid) begin
        chk(k == ncyc, "R6 completion after last cycle", 64'(k), 64'(ncyc));
        chk(rsp_err == (s == 2'd2), "R7 err flag", 64'(rsp_err), 64'(s == 2'd2));
        chk(rsp_rdata == exp_rd, "R5 result", 64'(rsp_rdata), 64'(exp_rd));
        if ($urandom % 2 == 0) begin
          rsp_ready = 1'b1;
          done = 1'b1;
        end
      end
      @(negedge clk);
      guard++;
      if (guard > 200) begin
        chk(1'b0, "R6 transfer hung", 64'(guard), 64'd0);
        done = 1'b1;
      end
    end
    bus_ready = 1'b0; rsp_ready = 1'b0;
    chk(!rsp_valid && !bus_valid, "R6 single completion", 64'({rsp_valid, bus_valid}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1 && !bus_valid && !rsp_valid, "R1 reset",
        64'({req_ready, bus_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    do_xfer(32'h0000_0003, 2'd1, 1'b1, 32'h0000_BEEF);  // R3 word across boundary
    do_xfer(32'h0000_0003, 2'd1, 1'b0, 32'h0);
    do_xfer(32'h0000_1001, 2'd1, 1'b1, 32'h0000_1234);  // R2 lanes 1,2
    do_xfer(32'h0000_1002, 2'd1, 1'b0, 32'h0);
    do_xfer(32'h0000_2001, 2'd3, 1'b1, 32'hDEAD_BEEF);  // R3 dword split
    do_xfer(32'h0000_2002, 2'd3, 1'b0, 32'h0);
    do_xfer(32'h0000_2003, 2'd3, 1'b0, 32'h0);
    do_xfer(32'h0000_3000, 2'd3, 1'b0, 32'h0);          // R2 aligned dword
    for (int o = 0; o < 4; o++) do_xfer(32'h40 + 32'(o), 2'd0, o[0], 32'h0000_00A5);
    do_xfer(32'hFFFF_FFFE, 2'd3, 1'b0, 32'h0);          // R3 wrap at top
    do_xfer(32'h0000_0101, 2'd2, 1'b1, 32'h1111_1111);  // R7 illegal size
    do_xfer(32'h0000_0102, 2'd2, 1'b0, 32'h0);
    for (int t = 0; t < 400; t++) begin
      logic [1:0] s;
      s = 2'($urandom);
      do_xfer($urandom, s, 1'($urandom), $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule